// File: doc/BRIEF.md
# Round-Subkey Expansion Engine

This block turns a user key into the full table of round subkeys for a rotation-based block cipher with 32-bit words. It first seeds an internal subkey table as an arithmetic progression from two fixed odd constants. It then runs a mixing loop with three passes in which the key words and the subkey table modify each other. The loop uses a fixed rotation and a rotation whose amount depends on the data. Each loop index wraps around its own table.

A key is offered on `key_in` with `key_valid`, and the engine accepts it by raising `key_take` in the same cycle. Expansion then runs without further input, at one mixing step per clock. As each subkey reaches its final value, the engine sends it to an external key memory through a write strobe, an address and a data bus. After the last of these writes, `done` goes high and stays high until the next key is accepted.

The controller has four states:
- `ST_IDLE`: after reset. The transition *accept* goes to `ST_SEED`.
- `ST_SEED`: the table is loaded. The transition *seeded* goes to `ST_MIX`.
- `ST_MIX`: the mixing steps run. When the step counter reaches its last value, the transition *mixed* goes to `ST_DONE`.
- `ST_DONE`: the table is complete. The transition *re-accept* goes back to `ST_SEED` when a new key arrives.

Top module: `rkx_expander`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `done`, `mem_we` and `key_take` are all low.
- R2: In `ST_IDLE` or `ST_DONE`, `key_take` is high in the same cycle as `key_valid`, and the key is captured at that clock edge. Key word j is `key_in[32*j+31:32*j]`, so key byte 0 (`key_in[7:0]`) is the least significant byte of word 0.
- R3: Seeding sets subkey k to 0xB7E15163 + k·0x9E3779B9, modulo 2^32, for k = 0 to T−1, where T = 2·ROUNDS+2 (26 by default).
- R4: Mixing starts with both accumulators at zero and both indices at zero, and runs 3·max(T, C) steps, one per clock, where C is the number of key words. In each step the subkey becomes rotl(S[i]+A+B, 3), and that result is the new A. The key word becomes rotl(L[j]+A+B, (A+B) mod 32), using the new A, and that result is the new B. Then i advances modulo T and j advances modulo C.
- R5: Exactly T memory writes occur for each key, in consecutive cycles, to addresses 0, 1, …, T−1 in ascending order. Each write carries the final value of that subkey.
- R6: Counting the accept cycle as cycle 0, the first memory write occurs in cycle 2 + 3·max(T, C) − T, which is cycle 54 by default.
- R7: `done` rises in the cycle after the write to address T−1 and stays high until a key is accepted. It is low in the cycle after that acceptance.
- R8: A `key_valid` that arrives during `ST_SEED` or `ST_MIX` is ignored: `key_take` stays low and the subkeys written are those of the key already accepted.
- R9: `mem_we` and `done` are never high together, and `key_take` is never high without `key_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| key_in | input | 8·KEY_BYTES | User key, byte 0 in the low bits |
| key_valid | input | 1 | A key is offered |
| key_take | output | 1 | The offered key is accepted this cycle |
| mem_we | output | 1 | Key memory write strobe |
| mem_addr | output | clog2(T) | Subkey index being written |
| mem_data | output | W | Final subkey value |
| done | output | 1 | Subkey table complete |

## Verification
The assertions assume that reset is held low across at least one rising edge before any key is offered. They also assume that `key_valid` is driven to a known level in every cycle. The address-sequence checks take for granted that no reset occurs in the middle of a write burst.

The stimulus respects these assumptions. It changes `key_in` and `key_valid` only on falling edges. It drops `key_valid` one cycle after acceptance, except in the deliberate busy-time offer, where it holds a different key for several cycles during mixing to show that the offer is ignored.

// File: rtl/rkx_pkg.sv
package rkx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEED,
        ST_MIX,
        ST_DONE
    } rkx_state_e;
endpackage

// File: rtl/rkx_mix_step.sv
module rkx_mix_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] s_cur,
    input  logic [W-1:0] l_cur,
    input  logic [W-1:0] a_cur,
    input  logic [W-1:0] b_cur,
    output logic [W-1:0] a_nxt,
    output logic [W-1:0] b_nxt
);
    localparam int SH = $clog2(W);

    logic [W-1:0]   sum_a;
    logic [W-1:0]   amt;
    logic [W-1:0]   sum_b;
    logic [2*W-1:0] dbl;

    always_comb begin
        sum_a = s_cur + a_cur + b_cur;
        a_nxt = {sum_a[W-4:0], sum_a[W-1:W-3]};
        amt   = a_nxt + b_cur;
        sum_b = l_cur + amt;
        dbl   = {sum_b, sum_b} << amt[SH-1:0];
        b_nxt = dbl[2*W-1:W];
    end
endmodule

// File: rtl/rkx_ctrl.sv
module rkx_ctrl
    import rkx_pkg::*;
#(
    parameter int T  = 26,
    parameter int C  = 4,
    parameter int IW = 5,
    parameter int JW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          key_valid,
    output logic          key_take,
    output logic          seed_en,
    output logic          mix_en,
    output logic          wr_en,
    output logic          done,
    output logic [IW-1:0] idx_s,
    output logic [JW-1:0] idx_l
);
    localparam int N  = 3 * ((T > C) ? T : C);
    localparam int NW = $clog2(N + 1);

    rkx_state_e    state, state_nxt;
    logic [NW-1:0] step;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (key_valid) state_nxt = ST_SEED;
            ST_SEED: state_nxt = ST_MIX;
            ST_MIX:  if (step == NW'(N - 1)) state_nxt = ST_DONE;
            ST_DONE: if (key_valid) state_nxt = ST_SEED;
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step  <= '0;
            idx_s <= '0;
            idx_l <= '0;
        end else if (state == ST_SEED) begin
            step  <= '0;
            idx_s <= '0;
            idx_l <= '0;
        end else if (state == ST_MIX) begin
            step  <= step + 1'b1;
            idx_s <= (idx_s == IW'(T - 1)) ? '0 : idx_s + 1'b1;
            idx_l <= (idx_l == JW'(C - 1)) ? '0 : idx_l + 1'b1;
        end
    end

    always_comb begin
        key_take = ((state == ST_IDLE) || (state == ST_DONE)) && key_valid;
        seed_en  = (state == ST_SEED);
        mix_en   = (state == ST_MIX);
        wr_en    = (state == ST_MIX) && (step >= NW'(N - T));
        done     = (state == ST_DONE);
    end
endmodule

// File: rtl/rkx_expander.sv
module rkx_expander #(
    parameter int          W         = 32,
    parameter int          KEY_BYTES = 16,
    parameter int          ROUNDS    = 12,
    parameter logic [31:0] MAGIC_P   = 32'hB7E15163,
    parameter logic [31:0] MAGIC_Q   = 32'h9E3779B9
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [8*KEY_BYTES-1:0]        key_in,
    input  logic                          key_valid,
    output logic                          key_take,
    output logic                          mem_we,
    output logic [$clog2(2*ROUNDS+2)-1:0] mem_addr,
    output logic [W-1:0]                  mem_data,
    output logic                          done
);
    localparam int T  = 2 * ROUNDS + 2;
    localparam int C  = (8 * KEY_BYTES) / W;
    localparam int IW = $clog2(T);
    localparam int JW = (C > 1) ? $clog2(C) : 1;

    logic [W-1:0]  s_tab [T];
    logic [W-1:0]  l_tab [C];
    logic [W-1:0]  acc_a, acc_b, a_nxt, b_nxt;
    logic          seed_en, mix_en, wr_en;
    logic [IW-1:0] idx_s;
    logic [JW-1:0] idx_l;

    rkx_ctrl #(.T(T), .C(C), .IW(IW), .JW(JW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_valid(key_valid),
        .key_take (key_take),
        .seed_en  (seed_en),
        .mix_en   (mix_en),
        .wr_en    (wr_en),
        .done     (done),
        .idx_s    (idx_s),
        .idx_l    (idx_l)
    );

    rkx_mix_step #(.W(W)) u_step (
        .s_cur(s_tab[idx_s]),
        .l_cur(l_tab[idx_l]),
        .a_cur(acc_a),
        .b_cur(acc_b),
        .a_nxt(a_nxt),
        .b_nxt(b_nxt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < T; k++) s_tab[k] <= '0;
            for (int k = 0; k < C; k++) l_tab[k] <= '0;
            acc_a <= '0;
            acc_b <= '0;
        end else begin
            if (key_take) begin
                for (int k = 0; k < C; k++) l_tab[k] <= key_in[k*W +: W];
            end
            if (seed_en) begin
                for (int k = 0; k < T; k++)
                    s_tab[k] <= W'(MAGIC_P) + W'(k) * W'(MAGIC_Q);
                acc_a <= '0;
                acc_b <= '0;
            end
            if (mix_en) begin
                s_tab[idx_s] <= a_nxt;
                l_tab[idx_l] <= b_nxt;
                acc_a        <= a_nxt;
                acc_b        <= b_nxt;
            end
        end
    end

    always_comb begin
        mem_we   = wr_en;
        mem_addr = idx_s;
        mem_data = a_nxt;
    end
endmodule

// File: rtl/rkx_expander_chk.sv
module rkx_expander_chk #(
    parameter int T  = 26,
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          key_valid,
    input logic          key_take,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          done
);
    // R9
    take_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_take |-> key_valid);

    // R9
    we_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && done));

    // R5
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr <= AW'(T - 1)));

    // R5
    addr_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 1'b1));

    // R7
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(mem_we) && $past(mem_addr) == AW'(T - 1)));

    // R7
    done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && key_take) |=> !done);

    // R8
    busy_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !key_take);
endmodule

bind rkx_expander rkx_expander_chk #(.T(2*ROUNDS+2), .AW($clog2(2*ROUNDS+2))) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_valid(key_valid),
    .key_take (key_take),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .done     (done)
);

// File: tb/rkx_expander_test.sv
`timescale 1ns/1ps
module rkx_expander_test;
    localparam int T = 26;
    localparam int C = 4;
    localparam int FIRST_WR = 54;
    localparam int DONE_AT  = 80;

    typedef struct {
        logic [4:0]  a;
        logic [31:0] d;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] key_in = '0;
    logic         key_valid = 1'b0;
    logic         key_take, mem_we, done;
    logic [4:0]   mem_addr;
    logic [31:0]  mem_data;

    int    n_chk = 0;
    int    n_bad = 0;
    int    ncount = 0;
    int    take_n = -1000;
    bit    first_seen = 1'b0;
    bit    done_prev = 1'b0;
    bit    finished = 1'b0;
    item_t expq[$];

    always #4 clk = ~clk;

    rkx_expander uut (
        .clk(clk), .rst_n(rst_n), .key_in(key_in), .key_valid(key_valid),
        .key_take(key_take), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_data(mem_data), .done(done)
    );

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        if (n == 0) return x;
        return (x << n) | (x >> (32 - n));
    endfunction

    task automatic check(input bit ok, input string msg);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s", msg);
        end
    endtask

    // Driver: compute expected subkeys (R3, R4) and queue them
    task automatic push_expected(input logic [127:0] k);
        logic [31:0] s [T];
        logic [31:0] l [C];
        logic [31:0] a, b;
        int i, j;
        for (int n = 0; n < T; n++) s[n] = 32'hB7E15163 + 32'(n) * 32'h9E3779B9;
        for (int n = 0; n < C; n++) l[n] = k[32*n +: 32];
        a = 0; b = 0; i = 0; j = 0;
        for (int n = 0; n < 3 * T; n++) begin
            a = rl(s[i] + a + b, 3);
            s[i] = a;
            b = rl(l[j] + a + b, int'((a + b) & 32'd31));
            l[j] = b;
            i = (i + 1) % T;
            j = (j + 1) % C;
        end
        for (int n = 0; n < T; n++) begin
            item_t it;
            it.a = 5'(n);
            it.d = s[n];
            expq.push_back(it);
        end
    endtask

    task automatic run_key(input logic [127:0] k, input bit intrude);
        push_expected(k);
        @(negedge clk);
        key_in = k;
        key_valid = 1'b1;
        #1;
        check(key_take === 1'b1, $sformatf("R2 key_take act=%b exp=1", key_take));
        take_n = ncount;
        first_seen = 1'b0;
        @(negedge clk);
        key_valid = 1'b0;
        #1;
        check(done === 1'b0, $sformatf("R7 done after accept act=%b exp=0", done));
        if (intrude) begin
            repeat (10) @(negedge clk);
            key_in = ~k ^ 128'h5A5A;
            key_valid = 1'b1;
            for (int n = 0; n < 5; n++) begin
                #1;
                check(key_take === 1'b0, $sformatf("R8 busy key_take act=%b exp=0", key_take));
                @(negedge clk);
            end
            key_valid = 1'b0;
        end
        while (done !== 1'b1) @(negedge clk);
        #1;
        check(expq.size() == 0, $sformatf("R5 pending writes act=%0d exp=0", expq.size()));
        repeat (3) @(negedge clk);
    endtask

    // Monitor: compare writes and timing against the queue
    always @(negedge clk) begin
        ncount++;
        if (rst_n) begin
            if (mem_we === 1'b1) begin
                if (!first_seen) begin
                    first_seen = 1'b1;
                    check(ncount - take_n == FIRST_WR,
                          $sformatf("R6 first write cycle act=%0d exp=%0d", ncount - take_n, FIRST_WR));
                end
                if (expq.size() == 0) begin
                    check(1'b0, $sformatf("R5 extra write act=%0d exp=none", mem_addr));
                end else begin
                    item_t e;
                    e = expq.pop_front();
                    check(mem_addr === e.a, $sformatf("R5 addr act=%0d exp=%0d", mem_addr, e.a));
                    check(mem_data === e.d, $sformatf("R4 R3 subkey[%0d] act=%h exp=%h", e.a, mem_data, e.d));
                end
            end
            if (done === 1'b1 && !done_prev)
                check(ncount - take_n == DONE_AT,
                      $sformatf("R7 done rise cycle act=%0d exp=%0d", ncount - take_n, DONE_AT));
            done_prev = (done === 1'b1);
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #800000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog act=timeout exp=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(done === 1'b0 && mem_we === 1'b0 && key_take === 1'b0,
              $sformatf("R1 reset outputs act=%b%b%b exp=000", done, mem_we, key_take));
        rst_n = 1'b1;
        @(negedge clk);
        check(done === 1'b0 && mem_we === 1'b0,
              $sformatf("R1 after reset act=%b%b exp=00", done, mem_we));
        run_key(128'h0, 1'b0);
        run_key({128{1'b1}}, 1'b0);
        run_key(128'h0F0E0D0C0B0A09080706050403020100, 1'b1);
        run_key(128'h91CEA91001A5556351B241BE19465F91, 1'b0);
        run_key(128'h00000000000000000000000000000001, 1'b0);
        finish_run();
    end
endmodule